// File: doc/BRIEF.md
# Synchronized Output Clock Stop Controller

This block sits between the clock synthesizers and the output pins of a clock generator and decides, cycle by cycle, which derived clocks reach the board. It manages two groups: a bank of processor clocks and a bank of managed bus clocks. Each group has its own active-low stop request, and a power-down override can turn both groups off at once. A free-running reference bus clock is passed straight through and is never gated. It also serves as the clock on which every request is sampled.

All requests may change at any moment. Each one passes through a two-flop synchronizer clocked by rising edges of the free-running reference. The synchronized result is then loaded into a per-group enable register on the falling edge of that group's own clock, so an enable can only change while its clock is low. Each gated output is the clock ANDed with its enable. As a result, an output always parks low, and every high pulse it emits has full width. The processor clock is assumed to be an integer multiple of the reference and rising-edge aligned with it. The stop requests and the override are plain level controls with no handshake.

Top module: `clkstop_ctrl`

## Requirements
- R1: While the processor-group request (`cpu_stop_ni`) is seen low after synchronization, every bit of `cpu_clk_o` stays low through whole clock periods, and the other outputs keep toggling.
- R2: While the bus-group request (`pci_stop_ni`) is seen low after synchronization, every bit of `pci_clk_o` stays low. `ref_clk_o` follows `clk_ref_i` at all times, whatever the requests, the override or the reset.
- R3: Call e1 and e2 the first and second rising edges of `clk_ref_i` after a request or override changes. A high phase of a gated output that begins at or before e2 reflects the previous request. A high phase that begins after e2 reflects the new one.
- R4: Every high pulse on `cpu_clk_o` and `pci_clk_o` lasts exactly half a period of its source clock, including the first pulse after a restart and the last pulse before a stop.
- R5: A group's enable changes only on a falling edge of that group's clock. Its value equals the synchronized request sampled at the previous falling edge.
- R6: While `force_off_i` is high, both gated groups are off, whatever the two stop requests. The override uses the same synchronizer and latency as the requests (R3).
- R7: While `rst_ni` is low, all gated outputs are low. Reset release counts as a request change for R3.
- R8: A request that goes low and returns high between two consecutive rising edges of `clk_ref_i` has no effect on any gated output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu_i | input | 1 | Processor-group source clock (integer multiple of the reference, edge-aligned) |
| clk_ref_i | input | 1 | Free-running reference bus clock; also the synchronizer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | Asynchronous processor-group run request, low = stop |
| pci_stop_ni | input | 1 | Asynchronous bus-group run request, low = stop |
| force_off_i | input | 1 | Asynchronous power-down override, high = both groups off |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated managed bus clocks |
| ref_clk_o | output | 1 | Ungated copy of the reference clock |

## Verification
The bench drives a directed sequence first: each group stopped alone, both stopped together, the override asserted with the requests both high and both low, and its release. This separates group independence (R1, R2) from override priority (R6). Random request and override changes then land at arbitrary non-edge offsets. A scoreboard predicts, from the e2 rule, the state of every gated high phase, which pins the synchronizer depth and the falling-edge load to the correct edge. A change-and-return pulse placed inside one reference period tells a true two-flop sampler apart from one that reacts to levels between edges (R8). Pulse-width monitors on the gated outputs detect any runt created by loading an enable while a clock is high (R4, R5).

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Smallest synchronizer depth the block accepts.
  localparam int unsigned MIN_SYNC = 2;

  // Run requests of the two gated groups, after the override is folded in.
  typedef struct packed {
    logic cpu;
    logic pci;
  } run_pair_t;

  function automatic run_pair_t fold_override(input logic cpu_n,
                                              input logic pci_n,
                                              input logic force_off);
    run_pair_t r;
    r.cpu = cpu_n & ~force_off;
    r.pci = pci_n & ~force_off;
    return r;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= req_i;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], req_i};
    end
  end

  assign sync_o = chain_q[STAGES-1];

  // Edge counter used only to keep the check away from pre-reset history.
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk2
    // R3: the output is the request as it stood two reference edges earlier.
    p_sync_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q >= 2'd2) |-> (sync_o == $past(req_i, 2)));
  end

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [WIDTH-1:0] gclk_o
);

  // Enable loaded only on the falling edge, while the clock is low.
  logic en_q;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign gclk_o[i] = clk_i & en_q;
  end

  // Checker state: enable seen at the rising edge, and a first-fall marker.
  logic en_rise_q;
  logic fall_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_rise_q <= 1'b0;
    else         en_rise_q <= en_q;
  end
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_seen_q <= 1'b0;
    else         fall_seen_q <= 1'b1;
  end

  // R4: the enable held through the whole high phase, so no pulse is cut short.
  p_en_steady_high_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    en_q == en_rise_q);

  // R5: the enable takes the run request sampled at the previous falling edge.
  p_en_follows_run_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    fall_seen_q |-> (en_q == $past(run_i)));

endmodule

// File: rtl/clkstop_group.sv
`timescale 1ns/1ps
module clkstop_group #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_ref_i,
  input  logic             clk_src_i,
  input  logic             rst_ni,
  input  logic             run_req_i,
  output logic             run_sync_o,
  output logic [WIDTH-1:0] gclk_o
);

  clkstop_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .req_i  (run_req_i),
    .sync_o (run_sync_o)
  );

  clkstop_gate #(.WIDTH(WIDTH)) u_gate (
    .clk_i  (clk_src_i),
    .rst_ni (rst_ni),
    .run_i  (run_sync_o),
    .gclk_o (gclk_o)
  );

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned N_CPU       = 2,
  parameter int unsigned N_PCI       = 5,
  parameter int unsigned SYNC_STAGES = MIN_SYNC
) (
  input  logic             clk_cpu_i,
  input  logic             clk_ref_i,
  input  logic             rst_ni,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             force_off_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             ref_clk_o
);

  run_pair_t run_req;
  run_pair_t run_sync;

  // Override folded in ahead of the synchronizers so it shares their latency.
  assign run_req = fold_override(cpu_stop_ni, pci_stop_ni, force_off_i);

  clkstop_group #(.WIDTH(N_CPU), .STAGES(SYNC_STAGES)) u_cpu_grp (
    .clk_ref_i  (clk_ref_i),
    .clk_src_i  (clk_cpu_i),
    .rst_ni     (rst_ni),
    .run_req_i  (run_req.cpu),
    .run_sync_o (run_sync.cpu),
    .gclk_o     (cpu_clk_o)
  );

  clkstop_group #(.WIDTH(N_PCI), .STAGES(SYNC_STAGES)) u_pci_grp (
    .clk_ref_i  (clk_ref_i),
    .clk_src_i  (clk_ref_i),
    .rst_ni     (rst_ni),
    .run_req_i  (run_req.pci),
    .run_sync_o (run_sync.pci),
    .gclk_o     (pci_clk_o)
  );

  assign ref_clk_o = clk_ref_i;

  // Edge counter used only by the override check below.
  logic [1:0] ref_seen_q;
  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni)                ref_seen_q <= '0;
    else if (ref_seen_q != 2'd3) ref_seen_q <= ref_seen_q + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_chk2
    // R6: an override seen two edges back has turned both groups off.
    p_force_off_r6: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
      ((ref_seen_q >= 2'd2) && $past(force_off_i, 2)) |->
        (!run_sync.cpu && !run_sync.pci));
  end

endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;

  localparam int N_CPU = 2;
  localparam int N_PCI = 5;

  logic clk_cpu = 1'b0;
  logic clk_ref = 1'b0;
  logic rst_n   = 1'b0;
  logic cpu_n   = 1'b1;
  logic pci_n   = 1'b1;
  logic force_off = 1'b0;
  logic [N_CPU-1:0] cpu_clk;
  logic [N_PCI-1:0] pci_clk;
  logic ref_clk;

  clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI)) uut (
    .clk_cpu_i   (clk_cpu),
    .clk_ref_i   (clk_ref),
    .rst_ni      (rst_n),
    .cpu_stop_ni (cpu_n),
    .pci_stop_ni (pci_n),
    .force_off_i (force_off),
    .cpu_clk_o   (cpu_clk),
    .pci_clk_o   (pci_clk),
    .ref_clk_o   (ref_clk)
  );

  // Reference at 50 MHz (rises at 5, 25, 45 ...); processor clock at twice that.
  initial forever begin
    #5 clk_cpu = ~clk_cpu;
    if (clk_cpu) clk_ref = ~clk_ref;
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Scoreboard: each request change becomes an item active after its e2 edge.
  typedef struct packed {
    longint t_e2;
    logic   cpu;
    logic   pci;
    logic   frc;
  } ev_t;
  ev_t q[$];
  ev_t cur = '0;

  function automatic longint next_ref_rise(input longint t);
    return 5 + 20 * ((t - 5) / 20 + 1);
  endfunction

  task automatic push_change();
    ev_t e;
    e.t_e2 = next_ref_rise($time) + 20;
    e.cpu  = cpu_n & ~force_off;
    e.pci  = pci_n & ~force_off;
    e.frc  = force_off;
    q.push_back(e);
  endtask

  task automatic apply(input logic c, input logic p, input logic f);
    if (($time % 5) == 0) #1;
    cpu_n = c; pci_n = p; force_off = f;
    push_change();
  endtask

  // Monitor: mid-high of every processor clock phase.
  always @(posedge clk_cpu) begin
    longint tr;
    bit ref_rise;
    #2;
    tr = $time - 2;
    while (q.size() > 0 && q[0].t_e2 < tr) cur = q.pop_front();
    ref_rise = ((tr - 5) % 20) == 0;
    chk(cpu_clk == {N_CPU{cur.cpu}}, cur.frc ? "R6 R1 R3 cpu" : "R1 R3 cpu",
        8'(cpu_clk), 8'({N_CPU{cur.cpu}}));
    chk(ref_clk == ref_rise, "R2 ref", 8'(ref_clk), 8'(ref_rise));
    if (ref_rise)
      chk(pci_clk == {N_PCI{cur.pci}}, cur.frc ? "R6 R2 R3 pci" : "R2 R3 pci",
          8'(pci_clk), 8'({N_PCI{cur.pci}}));
    else
      chk(pci_clk == '0, "R2 pci low phase", 8'(pci_clk), 8'h00);
  end

  // Pulse-width monitors (R4 R5): no runt high pulse on any gated output.
  longint t_cr, t_pr;
  always @(posedge cpu_clk[0]) t_cr = $time;
  always @(negedge cpu_clk[0]) chk(($time - t_cr) == 5, "R4 R5 cpu width",
                                   8'($time - t_cr), 8'd5);
  always @(posedge pci_clk[N_PCI-1]) t_pr = $time;
  always @(negedge pci_clk[N_PCI-1]) chk(($time - t_pr) == 10, "R4 R5 pci width",
                                         8'($time - t_pr), 8'd10);

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R7: outputs low under reset even though both requests ask to run.
    #50;
    chk(cpu_clk == '0 && pci_clk == '0, "R7 reset", 8'({cpu_clk, pci_clk}), 8'h00);
    #53;
    rst_n = 1'b1;
    push_change();
    #300;
    // Directed group patterns.
    apply(0, 1, 0); #200;   // processor group alone
    apply(1, 0, 0); #200;   // bus group alone
    apply(0, 0, 0); #200;   // both
    apply(1, 1, 0); #200;
    apply(1, 1, 1); #200;   // R6 override with requests running
    apply(0, 0, 1); #100;
    apply(1, 1, 1); #100;
    apply(1, 1, 0); #200;   // release
    // R8: stop request pulse that misses every reference edge.
    @(posedge clk_ref); #3;
    apply(0, 0, 0); #6;
    apply(1, 1, 0); #200;
    // Random asynchronous timing.
    for (int i = 0; i < 80; i++) begin
      int unsigned d;
      logic c, p, f;
      d = $urandom_range(3, 260);
      #(d);
      c = 1'($urandom_range(0, 1));
      p = 1'($urandom_range(0, 1));
      f = ($urandom_range(0, 5) == 0);
      apply(c, p, f);
    end
    #300;
    finish_run();
  end

endmodule